// File: doc/BRIEF.md
# External Master Chip-Select Controller

This block lets a bus master outside the chip, running on the same clock, reach external memory through the chip's chip-select logic. When the master's transfer-start strobe is high at a rising edge, the block captures the address. On the next edge it classifies the address. On the edge after that it acts on the result. An address in the chip's internal space is left alone, because an internal target serves it. An address that falls in the internal flash window while flash is switched off ends with a single-cycle transfer error. An address that matches one of the programmable external regions drives that region's chip select. For such a hit the block can also issue a memory start pulse in the same cycle as chip select, and then returns transfer acknowledges, one per beat. An external address that matches no region gets a transfer error from a bus-monitor timeout.

Region matching does not use the full address. It uses a compare value built from eight zero bits followed by the nine address bits numbered 8 to 16 in big-endian order, which are `addr[23:15]`. Each region holds a base, a mask, a valid flag and a wait-state count, and is set through static configuration ports. The transfer interface is a plain synchronous strobe protocol and not valid/ready. The master keeps the address stable until the last acknowledge, so there is no back-pressure path. A second start strobe that arrives while a transfer is in progress is dropped.

Top module: `emc_xmaster_cs`

## Requirements
- R1: While reset is active and right after it, every `cs_n` bit is 1 and `mem_start`, `xfer_ack` and `xfer_err` are 0.
- R2: The compare value is `{8'b0, addr[23:15]}`. Region k matches when `rgn_valid[k]` is set and (compare AND mask_k) equals (base_k AND mask_k). Address bits outside `[23:15]` do not affect an external match, and bit 23 is compared.
- R3: An address with `addr[31:22] == 0` is internal. When it is not an error case under R8, it produces no chip select, no acknowledge, no error and no start pulse.
- R4: For a region hit whose start strobe is sampled at edge t, `cs_n[k]` goes low at edge t+2.
- R5: When `strobe_en` is 1, `mem_start` is high for exactly the first chip-select cycle. When `strobe_en` is 0, `mem_start` stays 0.
- R6: With a wait count W for the region, each beat's `xfer_ack` is high for one cycle after W cycles of chip select with no acknowledge. The first acknowledge comes at edge t+2+W.
- R7: `burst_more` is sampled in each acknowledge cycle. If it is 1, another beat follows. If it is 0, that beat is the last one, and `cs_n` returns high at the next edge.
- R8: An internal address with `addr[21] == 0` is the flash window. If `flash_off` is 1, `xfer_err` is high for one cycle at edge t+2, with no chip select and no acknowledge. If `flash_off` is 0, the access is ignored as described in R3.
- R9: An external address that matches no region produces no chip select and no acknowledge. `xfer_err` is then high for one cycle at edge t+2+16.
- R10: A start strobe sampled while a transfer is in progress has no effect.
- R11: When several regions match, the lowest-numbered one drives its chip select and sets the wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the external master |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Transfer start from the external master, active high |
| addr | input | 32 | Master address, bit 31 is the MSB |
| burst_more | input | 1 | High in an acknowledge cycle when more beats follow |
| flash_off | input | 1 | Internal flash disabled |
| strobe_en | input | 1 | Enables the memory start pulse |
| rgn_base | input | 68 | Four 17-bit region bases, region k at `[17k +: 17]` |
| rgn_mask | input | 68 | Four 17-bit region masks, region k at `[17k +: 17]` |
| rgn_valid | input | 4 | Region valid flags |
| rgn_wait | input | 16 | Four 4-bit wait counts, region k at `[4k +: 4]` |
| cs_n | output | 4 | Active-low region chip selects |
| mem_start | output | 1 | Memory start pulse, aligned to chip select |
| xfer_ack | output | 1 | Transfer acknowledge, one pulse per beat |
| xfer_err | output | 1 | Transfer error |

## Verification
Some properties are checked on every cycle by the assertions:
- At most one chip select is active at a time.
- An acknowledge never occurs without chip select, and never in the same cycle as an error.
- The start pulse and the error each last one cycle.
- Chip select only ever starts from the decode step.
- A busy transfer never goes back to the capture step.

Other behaviour can only be shown by the bench scenarios, because it depends on the stimulus. This covers the exact cycle each output moves in relation to the start strobe, the spacing of wait states, where a burst ends, the region chosen when regions overlap, the slice used for matching, and whether internal or unmatched addresses stay silent or raise an error at the right moment.

// File: rtl/emc_pkg.sv
package emc_pkg;
  typedef enum logic [1:0] {K_IGNORE, K_FLASH, K_HIT, K_MISS} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_CAPT, S_DECD, S_DATA, S_TMO, S_ERR} state_e;
endpackage

// File: rtl/emc_space_decode.sv
module emc_space_decode #(
  parameter int ADDR_W    = 32,
  parameter int INT_LSB   = 22,
  parameter int INT_TAG   = 0,
  parameter int FLASH_BIT = 21,
  parameter int SLICE_LO  = 15,
  parameter int SLICE_W   = 9,
  parameter int ZPAD_W    = 8,
  localparam int CMP_W    = ZPAD_W + SLICE_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_int,
  output logic              is_flash,
  output logic [CMP_W-1:0]  cmp
);
  localparam int TAG_W = ADDR_W - INT_LSB;

  // internal space is identified by the top address bits alone
  assign is_int   = (addr[ADDR_W-1:INT_LSB] == TAG_W'(INT_TAG));
  assign is_flash = is_int && !addr[FLASH_BIT];
  // narrow external window: zero pad above the region slice
  assign cmp      = {{ZPAD_W{1'b0}}, addr[SLICE_LO+SLICE_W-1:SLICE_LO]};
endmodule

// File: rtl/emc_region_match.sv
module emc_region_match #(
  parameter int NREG  = 4,
  parameter int CMP_W = 17,
  parameter int WS_W  = 4,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [CMP_W-1:0]      cmp,
  input  logic [NREG*CMP_W-1:0] base,
  input  logic [NREG*CMP_W-1:0] mask,
  input  logic [NREG-1:0]       valid,
  input  logic [NREG*WS_W-1:0]  waits,
  output logic                  hit,
  output logic [IDX_W-1:0]      idx,
  output logic [WS_W-1:0]       wait_sel
);
  logic [NREG-1:0] match;

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    logic [CMP_W-1:0] m;
    assign m        = mask[g*CMP_W +: CMP_W];
    assign match[g] = valid[g] && ((cmp & m) == (base[g*CMP_W +: CMP_W] & m));
  end

  // lowest index wins: scan downward so the last write is the smallest hit
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit      = |match;
  assign wait_sel = waits[idx*WS_W +: WS_W];
endmodule

// File: rtl/emc_beat_fsm.sv
module emc_beat_fsm
  import emc_pkg::*;
#(
  parameter int NREG = 4,
  parameter int WS_W = 4,
  parameter int TMO  = 16,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TMO_W = (TMO > 1) ? $clog2(TMO) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts,
  input  logic             burst_more,
  input  logic             mts_en,
  input  kind_e            kind_d,
  input  logic [IDX_W-1:0] idx_d,
  input  logic [WS_W-1:0]  wait_d,
  output logic             accept,
  output logic             cs_act,
  output logic [IDX_W-1:0] cs_sel,
  output logic             mts,
  output logic             ta,
  output logic             tea
);
  state_e           state_q;
  kind_e            kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [WS_W-1:0]  wait_q, wcnt_q;
  logic [TMO_W-1:0] tcnt_q;
  logic             cs_q, mts_q, ta_q, tea_q;

  assign accept = ts && (state_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_IGNORE;
      idx_q   <= '0;
      wait_q  <= '0;
      wcnt_q  <= '0;
      tcnt_q  <= '0;
      cs_q    <= 1'b0;
      mts_q   <= 1'b0;
      ta_q    <= 1'b0;
      tea_q   <= 1'b0;
    end else begin
      mts_q <= 1'b0;
      tea_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (ts) state_q <= S_CAPT;
        S_CAPT: begin
          kind_q  <= kind_d;
          idx_q   <= idx_d;
          wait_q  <= wait_d;
          state_q <= S_DECD;
        end
        S_DECD: begin
          unique case (kind_q)
            K_HIT: begin
              cs_q    <= 1'b1;
              mts_q   <= mts_en;
              wcnt_q  <= wait_q;
              ta_q    <= (wait_q == '0);
              state_q <= S_DATA;
            end
            K_FLASH: begin
              tea_q   <= 1'b1;
              state_q <= S_ERR;
            end
            K_MISS: begin
              tcnt_q  <= '0;
              state_q <= S_TMO;
            end
            default: state_q <= S_IDLE;
          endcase
        end
        S_DATA: begin
          if (ta_q) begin
            if (burst_more) begin
              wcnt_q <= wait_q;
              ta_q   <= (wait_q == '0);
            end else begin
              ta_q    <= 1'b0;
              cs_q    <= 1'b0;
              state_q <= S_IDLE;
            end
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
            if (wcnt_q == WS_W'(1)) ta_q <= 1'b1;
          end
        end
        S_TMO: begin
          if (tcnt_q == TMO_W'(TMO - 1)) begin
            tea_q   <= 1'b1;
            state_q <= S_ERR;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        S_ERR:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cs_act = cs_q;
  assign cs_sel = idx_q;
  assign mts    = mts_q;
  assign ta     = ta_q;
  assign tea    = tea_q;

  // R7 / R8: acknowledge only under chip select, never with an error
  a_r7_ack_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ta_q |-> cs_q);
  a_r8_ack_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ta_q && tea_q));
  // R5: start pulse is one cycle wide and sits on the first chip-select cycle
  a_r5_mts_single: assert property (@(posedge clk) disable iff (!rst_n)
    mts_q |=> !mts_q);
  a_r5_mts_first_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mts_q |-> (cs_q && !$past(cs_q)));
  // R4: chip select begins only out of the decode step
  a_r4_cs_from_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> ($past(state_q) == S_DECD));
  // R9 / R8: error pulses are single cycle
  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    tea_q |=> !tea_q);
  // R10: a busy controller never re-enters capture
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> (state_q != S_CAPT));
endmodule

// File: rtl/emc_xmaster_cs.sv
module emc_xmaster_cs
  import emc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NREG      = 4,
  parameter int SLICE_LO  = 15,
  parameter int SLICE_W   = 9,
  parameter int ZPAD_W    = 8,
  parameter int WS_W      = 4,
  parameter int TMO       = 16,
  parameter int INT_LSB   = 22,
  parameter int INT_TAG   = 0,
  parameter int FLASH_BIT = 21,
  localparam int CMP_W    = ZPAD_W + SLICE_W,
  localparam int IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xfer_start,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  burst_more,
  input  logic                  flash_off,
  input  logic                  strobe_en,
  input  logic [NREG*CMP_W-1:0] rgn_base,
  input  logic [NREG*CMP_W-1:0] rgn_mask,
  input  logic [NREG-1:0]       rgn_valid,
  input  logic [NREG*WS_W-1:0]  rgn_wait,
  output logic [NREG-1:0]       cs_n,
  output logic                  mem_start,
  output logic                  xfer_ack,
  output logic                  xfer_err
);
  logic [ADDR_W-1:0] addr_q;
  logic              accept, is_int, is_flash, hit, cs_act;
  logic [CMP_W-1:0]  cmp;
  logic [IDX_W-1:0]  idx, cs_sel;
  logic [WS_W-1:0]   wait_sel;
  kind_e             kind_d;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= addr;
  end

  emc_space_decode #(
    .ADDR_W(ADDR_W), .INT_LSB(INT_LSB), .INT_TAG(INT_TAG), .FLASH_BIT(FLASH_BIT),
    .SLICE_LO(SLICE_LO), .SLICE_W(SLICE_W), .ZPAD_W(ZPAD_W)
  ) u_space (
    .addr(addr_q), .is_int(is_int), .is_flash(is_flash), .cmp(cmp)
  );

  emc_region_match #(.NREG(NREG), .CMP_W(CMP_W), .WS_W(WS_W)) u_match (
    .cmp(cmp), .base(rgn_base), .mask(rgn_mask), .valid(rgn_valid),
    .waits(rgn_wait), .hit(hit), .idx(idx), .wait_sel(wait_sel)
  );

  // internal space takes precedence over any region hit
  always_comb begin
    if (is_flash && flash_off) kind_d = K_FLASH;
    else if (is_int)           kind_d = K_IGNORE;
    else if (hit)              kind_d = K_HIT;
    else                       kind_d = K_MISS;
  end

  emc_beat_fsm #(.NREG(NREG), .WS_W(WS_W), .TMO(TMO)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ts(xfer_start), .burst_more(burst_more),
    .mts_en(strobe_en), .kind_d(kind_d), .idx_d(idx), .wait_d(wait_sel),
    .accept(accept), .cs_act(cs_act), .cs_sel(cs_sel), .mts(mem_start),
    .ta(xfer_ack), .tea(xfer_err)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_cs
    assign cs_n[k] = !(cs_act && (cs_sel == IDX_W'(k)));
  end

  // R4 / R11: never more than one chip select at a time
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R5: start pulse only with an active chip select
  a_r5_mts_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |-> (cs_n != {NREG{1'b1}}));
endmodule

// File: tb/tb_emc_xmaster_cs.sv
module tb_emc_xmaster_cs;
  typedef struct {
    int         cyc;
    logic [3:0] csn;
    logic       mts;
    logic       ta;
    logic       tea;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 1'b0;
  logic [31:0] addr = '0;
  logic        burst_more = 1'b0;
  logic        flash_off = 1'b0;
  logic        strobe_en = 1'b1;
  logic [67:0] rgn_base, rgn_mask;
  logic [3:0]  rgn_valid;
  logic [15:0] rgn_wait;
  logic [3:0]  cs_n;
  logic        mem_start, xfer_ack, xfer_err;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  emc_xmaster_cs dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .addr(addr),
    .burst_more(burst_more), .flash_off(flash_off), .strobe_en(strobe_en),
    .rgn_base(rgn_base), .rgn_mask(rgn_mask), .rgn_valid(rgn_valid),
    .rgn_wait(rgn_wait), .cs_n(cs_n), .mem_start(mem_start),
    .xfer_ack(xfer_ack), .xfer_err(xfer_err)
  );

  // regions: 0 = 0x010..0x01F w0, 1 = 0x040..0x07F w2, 2 = 0x014 w1, 3 invalid
  initial begin
    rgn_base  = {17'h00100, 17'h00014, 17'h00040, 17'h00010};
    rgn_mask  = {17'h1FFFF, 17'h1FFFF, 17'h1FFC0, 17'h1FFF0};
    rgn_valid = 4'b0111;
    rgn_wait  = {4'd3, 4'd1, 4'd2, 4'd0};
  end

  function automatic logic [31:0] ext(input int slice);
    return 32'h0100_0000 | (32'(slice) << 15);
  endfunction

  task automatic compare(input exp_t e);
    n_cmp++;
    if (cs_n !== e.csn || mem_start !== e.mts || xfer_ack !== e.ta || xfer_err !== e.tea) begin
      n_bad++;
      $display("FAIL %s cyc %0d: got cs_n=%b mts=%b ack=%b err=%b exp cs_n=%b mts=%b ack=%b err=%b",
               e.tag, cyc, cs_n, mem_start, xfer_ack, xfer_err, e.csn, e.mts, e.ta, e.tea);
    end
  endtask

  // monitor: every cycle either matches the scheduled item or must be idle
  always @(negedge clk) begin
    if (mon_on && !done) begin
      exp_t e;
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        e = exp_q.pop_front();
      end else begin
        e.cyc = cyc; e.csn = 4'hF; e.mts = 1'b0; e.ta = 1'b0; e.tea = 1'b0;
        e.tag = "R3 idle";
      end
      compare(e);
    end
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // region hit: schedule chip select, start pulse and beat acknowledges
  task automatic hit_xfer(input logic [31:0] a, input int k, input int w, input int beats,
                          input bit en, input bit poke, input string tag);
    int t, tlast;
    strobe_en  = en;
    addr       = a;
    xfer_start = 1'b1;
    t          = cyc + 1;
    tlast      = t + 2 + w + (beats - 1) * (w + 1);
    for (int c = t + 2; c <= tlast; c++) begin
      exp_t e;
      int   d;
      d     = c - (t + 2 + w);
      e.cyc = c;
      e.csn = ~(4'b0001 << k);
      e.mts = en && (c == t + 2);
      e.ta  = (d >= 0) && ((d % (w + 1)) == 0);
      e.tea = 1'b0;
      e.tag = tag;
      exp_q.push_back(e);
    end
    burst_more = (beats > 1);
    @(negedge clk);
    xfer_start = 1'b0;
    if (poke) begin
      wait_cyc(t + 1);
      xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
    end
    wait_cyc(tlast);
    burst_more = 1'b0;
    wait_cyc(tlast + 1);
  endtask

  // no hit: optional single error pulse at t+err_off, otherwise silence
  task automatic err_xfer(input logic [31:0] a, input int err_off, input string tag);
    int t, tend;
    addr       = a;
    xfer_start = 1'b1;
    t          = cyc + 1;
    if (err_off >= 0) begin
      exp_t e;
      e.cyc = t + err_off; e.csn = 4'hF; e.mts = 1'b0; e.ta = 1'b0; e.tea = 1'b1;
      e.tag = tag;
      exp_q.push_back(e);
    end
    tend = (err_off >= 0) ? t + err_off + 1 : t + 2;
    @(negedge clk);
    xfer_start = 1'b0;
    wait_cyc(tend);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    begin : r1_reset_check
      exp_t e;
      e.cyc = cyc; e.csn = 4'hF; e.mts = 1'b0; e.ta = 1'b0; e.tea = 1'b0; e.tag = "R1";
      compare(e);
    end
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    @(negedge clk);

    hit_xfer(ext(12'h012), 0, 0, 1, 1'b1, 1'b0, "R4");  // single beat, no wait
    hit_xfer(ext(12'h05A), 1, 2, 1, 1'b1, 1'b0, "R6");  // two wait states
    hit_xfer(ext(12'h041), 1, 2, 3, 1'b1, 1'b0, "R7");  // three-beat burst with waits
    hit_xfer(ext(12'h014), 0, 0, 4, 1'b1, 1'b0, "R11"); // regions 0 and 2 both match
    hit_xfer(ext(12'h013), 0, 0, 2, 1'b0, 1'b0, "R5");  // start pulse disabled
    // R2: bits outside the slice (24, 25, 14) do not disturb the match
    hit_xfer(32'h0300_4000 | (32'h015 << 15), 0, 0, 1, 1'b1, 1'b0, "R2");
    hit_xfer(ext(12'h07F), 1, 2, 2, 1'b1, 1'b1, "R10"); // extra start while busy
    err_xfer(ext(12'h110), 18, "R2");   // slice MSB set breaks region 0 match -> timeout
    err_xfer(ext(12'h100), 18, "R9");   // only invalid region 3 would match
    err_xfer(ext(12'h0A0), 18, "R9");
    flash_off = 1'b1;
    err_xfer(32'h0020_0000, -1, "R3");  // internal, outside flash window
    err_xfer(32'h0000_1000, 2, "R8");   // flash window while flash is off
    flash_off = 1'b0;
    err_xfer(32'h0000_1000, -1, "R8");  // flash window, flash on: ignored
    hit_xfer(ext(12'h01F), 0, 0, 1, 1'b1, 1'b0, "R4");

    repeat (4) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R7 leftover items: got %0d expected 0", exp_q.size());
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
    end
  end
endmodule